// File: doc/BRIEF.md
# Acquisition Instruction Store and Sequencer

This block keeps a small program of acquisition instructions and steps through it, one instruction at a time. For each instruction it hands the fields to a conversion engine, waits for that engine to finish, and then moves on. It holds eight instructions of 48 bits each. Each instruction is split into three 16-bit sections. Section 0 carries the input-select code, the resolution choice, the acquisition time and a loop-end mark. Sections 1 and 2 each carry one signed threshold with a direction flag. When a conversion result comes back, the block compares it with both thresholds and reports the result together with two trip bits.

A host reaches the instructions and a configuration word through a parallel register bus that is either 16 or 8 bits wide. The host does not address the three sections directly. A 2-bit section pointer in the configuration word selects which section an access to an instruction address reaches. The host may read and write the instruction store only while the sequencer is stopped. A write made while the sequencer runs is dropped and leaves a sticky error flag.

The host starts the sequencer with a start bit. Clearing that bit lets the instruction in progress finish before the sequencer stops. A soft-reset bit stops it at once and rewinds it to instruction 0. The conversion itself is outside the block. It is modelled as a request/done handshake that returns a signed 13-bit result.

Top module: `acq_seq_top`

## Requirements
- R1: After `rstN` is released, `convReq` and `resValid` are 0 and the configuration word reads 0. The first instruction run after reset is instruction 0.
- R2: Address map on the 16-bit bus (`byteMode`=0): word index `hostAddr[4:1]` values 0–7 select an instruction and value 8 selects the configuration word. An instruction access reaches the section named by configuration bits 9:8, using values 0–2. With the pointer at 3, instruction writes are dropped and instruction reads return 0.
- R3: On the 8-bit bus (`byteMode`=1), `hostAddr[0]` selects the low byte (0) or the high byte (1). Write data is taken from `hostWrData[7:0]`, and a read returns the selected byte in `hostRdData[7:0]` with the upper bits 0.
- R4: Sections can be written in any order of instruction and section. Each one reads back the value last written to it.
- R5: While `convReq` is high, `convChannel` shows section 0 bits 9:0 of the current instruction, `convHiRes` shows bit 10 and `convAcqTime` shows bits 15:12. `convIndex` gives the instruction number.
- R6: With start (configuration bit 0) set and the sequencer idle, `convReq` rises on the next clock. It stays high until `convDone` is sampled. It is then low for exactly one cycle before the next instruction's request. After instruction 7, or after any instruction with section 0 bit 11 set, the next instruction is 0; otherwise it is the next number.
- R7: In the cycle after `convDone` is sampled, `resValid` is high for one cycle. `resData` then carries the captured result and `resIndex` the instruction that produced it.
- R8: Threshold section layout: bits 7:0 hold the magnitude, bit 8 the sign (1 means negative) and bit 9 the direction. With direction 1 the trip bit is set when result > threshold; with direction 0 it is set when result < threshold. `resTrip[0]` comes from section 1 and `resTrip[1]` from section 2.
- R9: If start is cleared while a request is pending, the request stays high until `convDone`. No further request follows, and a later start resumes at the next instruction.
- R10: Writing 1 to configuration bit 1 clears start, the instruction pointer, a pending request and the error flag, all at that clock. Bit 1 reads 1 for the following cycle only.
- R11: While the sequencer runs (start set or a request pending), instruction writes are dropped and set the sticky error flag, which is configuration bit 10. Instruction reads return 0 during that time. The flag stays set until a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteMode | input | 1 | 1 selects the 8-bit host bus |
| hostAddr | input | 5 | Host register address |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data, combinational from address |
| convReq | output | 1 | Conversion request for the current instruction |
| convIndex | output | 3 | Number of the current instruction |
| convChannel | output | 10 | Input-select code of the current instruction |
| convHiRes | output | 1 | Resolution choice of the current instruction |
| convAcqTime | output | 4 | Acquisition time of the current instruction |
| convDone | input | 1 | Conversion finished |
| convResult | input | 13 | Signed conversion result |
| resValid | output | 1 | Result pulse |
| resData | output | 13 | Captured signed result |
| resIndex | output | 3 | Instruction that produced the result |
| resTrip | output | 2 | Threshold trip bits, limit 2 in bit 1 and limit 1 in bit 0 |

## Verification
If the instruction pointer goes wrong, the very next request shows the wrong `convIndex` and wrong fields, and `resIndex` is wrong one cycle after `convDone`. That is why every serviced request checks the index and all section-0 fields. If the run/stop state is wrong, it shows within one cycle: either a request appears where start was cleared or reset, or a host write lands or is dropped wrongly, which the sticky flag and a later read-back expose. Thresholds are checked on every result, so a mis-decoded sign or direction shows up as a wrong trip bit on the same pulse.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int SEC_W   = 16;
  localparam int NUM_SEC = 3;
  localparam int CH_W    = 10;
  localparam int ACQ_W   = 4;

  // configuration word bit positions
  localparam int CFG_START  = 0;
  localparam int CFG_RESET  = 1;
  localparam int CFG_SEC_LO = 8;
  localparam int CFG_ERR    = 10;

  // section 0 bit positions
  localparam int S0_HIRES = 10;
  localparam int S0_LOOP  = 11;
  localparam int S0_ACQ   = 12;

  // threshold section bit positions
  localparam int LIM_SIGN = 8;
  localparam int LIM_DIR  = 9;

  typedef enum logic [0:0] {SEQ_IDLE, SEQ_BUSY} seqState_t;

  typedef struct packed {
    logic ramWe;
    logic laneLo;
    logic laneHi;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/seq_control.sv
module seq_control
  import acq_seq_pkg::*;
#(
  parameter int NUM_INSTR = 8,
  parameter int PTR_W     = 3,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic [SEC_W-1:0]  hostWrData,
  input  logic              convDone,
  input  logic              curLoopEnd,
  output dpStrobe_t         strobe,
  output logic [SEC_W-1:0]  wrWord,
  output logic [1:0]        secSel,
  output logic [PTR_W-1:0]  ptr,
  output logic [SEC_W-1:0]  cfgWord,
  output logic              running,
  output logic              convReq
);
  localparam logic [PTR_W:0]   CFG_IDX  = (PTR_W+1)'(NUM_INSTR);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_INSTR - 1);

  seqState_t  state;
  logic       startBit, resetBit, errFlag;
  logic [PTR_W:0] wordIdx;
  logic       laneLo, laneHi, isCfg, isRam;
  logic       cfgLoWr, cfgHiWr, softNow, errSet;
  logic [PTR_W-1:0] nextPtr;

  assign wordIdx = hostAddr[ADDR_W-1:1];
  assign laneLo  = !byteMode || !hostAddr[0];
  assign laneHi  = !byteMode ||  hostAddr[0];
  assign wrWord  = byteMode ? {hostWrData[7:0], hostWrData[7:0]} : hostWrData;
  assign isCfg   = (wordIdx == CFG_IDX);
  assign isRam   = (wordIdx < CFG_IDX);
  assign cfgLoWr = hostWr && isCfg && laneLo;
  assign cfgHiWr = hostWr && isCfg && laneHi;
  assign softNow = cfgLoWr && wrWord[CFG_RESET];

  assign convReq = (state == SEQ_BUSY);
  assign running = startBit || convReq;
  assign errSet  = hostWr && isRam && running;

  assign nextPtr = (curLoopEnd || ptr == LAST_PTR) ? '0 : ptr + 1'b1;

  always_comb begin
    strobe.ramWe   = hostWr && isRam && !running && (secSel != 2'd3);
    strobe.laneLo  = laneLo;
    strobe.laneHi  = laneHi;
    strobe.capture = convReq && convDone && !softNow;
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[CFG_START] = startBit;
    cfgWord[CFG_RESET] = resetBit;
    cfgWord[CFG_SEC_LO +: 2] = secSel;
    cfgWord[CFG_ERR] = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      startBit <= 1'b0;
      resetBit <= 1'b0;
      errFlag  <= 1'b0;
      secSel   <= 2'd0;
      ptr      <= '0;
    end else begin
      resetBit <= 1'b0;
      if (softNow) begin
        state    <= SEQ_IDLE;
        startBit <= 1'b0;
        resetBit <= 1'b1;
        errFlag  <= 1'b0;
        ptr      <= '0;
      end else begin
        if (cfgLoWr) startBit <= wrWord[CFG_START];
        if (errSet)  errFlag  <= 1'b1;
        case (state)
          SEQ_IDLE: if (startBit) state <= SEQ_BUSY;
          SEQ_BUSY: if (convDone) begin
            state <= SEQ_IDLE;
            ptr   <= nextPtr;
          end
          default: state <= SEQ_IDLE;
        endcase
      end
      if (cfgHiWr) secSel <= wrWord[CFG_SEC_LO +: 2];
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone && !softNow |=> convReq); // R6
  AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone && !softNow |=> $stable(ptr)); // R5
  AST_RESET_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    resetBit |-> !startBit && !convReq && ptr == '0 && !errFlag); // R10
  AST_RESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    resetBit && !softNow |=> !resetBit); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !softNow |=> errFlag); // R11
  AST_STOP_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !startBit && !convReq |=> !convReq); // R9
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import acq_seq_pkg::*;
#(
  parameter int NUM_INSTR = 8,
  parameter int RES_W     = 13,
  parameter int PTR_W     = 3,
  parameter int ADDR_W    = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic                    byteMode,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic [SEC_W-1:0]        wrWord,
  input  logic [1:0]              secSel,
  input  logic [PTR_W-1:0]        ptr,
  input  logic [SEC_W-1:0]        cfgWord,
  input  logic                    running,
  input  logic signed [RES_W-1:0] convResult,
  output logic [SEC_W-1:0]        hostRdData,
  output logic [CH_W-1:0]         convChannel,
  output logic                    convHiRes,
  output logic [ACQ_W-1:0]        convAcqTime,
  output logic                    curLoopEnd,
  output logic                    resValid,
  output logic signed [RES_W-1:0] resData,
  output logic [PTR_W-1:0]        resIndex,
  output logic [1:0]              resTrip
);
  localparam logic [PTR_W:0] CFG_IDX = (PTR_W+1)'(NUM_INSTR);
  localparam int CMP_W = RES_W + 1;

  logic [NUM_INSTR-1:0][NUM_SEC-1:0][SEC_W-1:0] instWord;
  logic [PTR_W-1:0] wrIdx;
  logic [PTR_W:0]   rdIdx;
  logic [SEC_W-1:0] rdWord, cur0;

  assign wrIdx = hostAddr[PTR_W:1];
  assign rdIdx = hostAddr[ADDR_W-1:1];

  for (genvar gi = 0; gi < NUM_INSTR; gi++) begin : g_instr
    logic [NUM_SEC-1:0][SEC_W-1:0] secQ;
    logic hit;
    assign hit = strobe.ramWe && (wrIdx == PTR_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        secQ <= '0;
      end else if (hit) begin
        if (strobe.laneLo) secQ[secSel][7:0]  <= wrWord[7:0];
        if (strobe.laneHi) secQ[secSel][15:8] <= wrWord[15:8];
      end
    end
    assign instWord[gi] = secQ;
  end

  always_comb begin
    rdWord = '0;
    if (rdIdx == CFG_IDX)
      rdWord = cfgWord;
    else if (rdIdx < CFG_IDX && !running && secSel != 2'd3)
      rdWord = instWord[rdIdx[PTR_W-1:0]][secSel];
  end

  assign hostRdData = !byteMode ? rdWord
                    : {8'h00, (hostAddr[0] ? rdWord[15:8] : rdWord[7:0])};

  assign cur0        = instWord[ptr][0];
  assign convChannel = cur0[CH_W-1:0];
  assign convHiRes   = cur0[S0_HIRES];
  assign convAcqTime = cur0[S0_ACQ +: ACQ_W];
  assign curLoopEnd  = cur0[S0_LOOP];

  function automatic logic limitTrip(input logic signed [RES_W-1:0] r,
                                     input logic [SEC_W-1:0] sec);
    logic signed [CMP_W-1:0] lim, rv;
    lim = $signed({{(CMP_W-8){1'b0}}, sec[7:0]});
    if (sec[LIM_SIGN]) lim = -lim;
    rv = {r[RES_W-1], r};
    return sec[LIM_DIR] ? (rv > lim) : (rv < lim);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resData  <= '0;
      resIndex <= '0;
      resTrip  <= 2'b00;
    end else begin
      resValid <= strobe.capture;
      if (strobe.capture) begin
        resData  <= convResult;
        resIndex <= ptr;
        resTrip  <= {limitTrip(convResult, instWord[ptr][2]),
                     limitTrip(convResult, instWord[ptr][1])};
      end
    end
  end

  AST_RAM_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ramWe |-> !running); // R11
  AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R7
endmodule

// File: rtl/acq_seq_top.sv
module acq_seq_top
  import acq_seq_pkg::*;
#(
  parameter  int NUM_INSTR = 8,
  parameter  int RES_W     = 13,
  localparam int PTR_W     = $clog2(NUM_INSTR),
  localparam int ADDR_W    = PTR_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    byteMode,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic                    hostWr,
  input  logic [15:0]             hostWrData,
  output logic [15:0]             hostRdData,
  output logic                    convReq,
  output logic [PTR_W-1:0]        convIndex,
  output logic [9:0]              convChannel,
  output logic                    convHiRes,
  output logic [3:0]              convAcqTime,
  input  logic                    convDone,
  input  logic signed [RES_W-1:0] convResult,
  output logic                    resValid,
  output logic signed [RES_W-1:0] resData,
  output logic [PTR_W-1:0]        resIndex,
  output logic [1:0]              resTrip
);
  dpStrobe_t        strobe;
  logic [SEC_W-1:0] wrWord, cfgWord;
  logic [1:0]       secSel;
  logic [PTR_W-1:0] ptr;
  logic             running, curLoopEnd;

  assign convIndex = ptr;

  seq_control #(.NUM_INSTR(NUM_INSTR), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostWrData(hostWrData), .convDone(convDone),
    .curLoopEnd(curLoopEnd), .strobe(strobe), .wrWord(wrWord),
    .secSel(secSel), .ptr(ptr), .cfgWord(cfgWord), .running(running),
    .convReq(convReq)
  );

  seq_datapath #(.NUM_INSTR(NUM_INSTR), .RES_W(RES_W), .PTR_W(PTR_W),
                 .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteMode(byteMode),
    .hostAddr(hostAddr), .wrWord(wrWord), .secSel(secSel), .ptr(ptr),
    .cfgWord(cfgWord), .running(running), .convResult(convResult),
    .hostRdData(hostRdData), .convChannel(convChannel),
    .convHiRes(convHiRes), .convAcqTime(convAcqTime),
    .curLoopEnd(curLoopEnd), .resValid(resValid), .resData(resData),
    .resIndex(resIndex), .resTrip(resTrip)
  );
endmodule

// File: tb/sim_acq_seq_top.sv
`timescale 1ns/1ps
module sim_acq_seq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteMode = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic        hostWr = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        convReq;
  logic [2:0]  convIndex;
  logic [9:0]  convChannel;
  logic        convHiRes;
  logic [3:0]  convAcqTime;
  logic        convDone = 1'b0;
  logic signed [12:0] convResult = '0;
  logic        resValid;
  logic signed [12:0] resData;
  logic [2:0]  resIndex;
  logic [1:0]  resTrip;

  int checks = 0;
  int fails = 0;
  int resSeed = 0;
  logic [15:0] model [8][3];

  always #10 clk = ~clk;

  acq_seq_top u0 (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .convReq(convReq), .convIndex(convIndex), .convChannel(convChannel),
    .convHiRes(convHiRes), .convAcqTime(convAcqTime), .convDone(convDone),
    .convResult(convResult), .resValid(resValid), .resData(resData),
    .resIndex(resIndex), .resTrip(resTrip)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int s);
    logic [15:0] v;
    v = 16'((i + 1) * 499 + s * 1191 + 197 + i * s * 77);
    if (s == 0) v[11] = 1'b0;
    return v;
  endfunction

  function automatic int expTrip(input int r, input logic [15:0] sec);
    int lim;
    lim = int'(sec[7:0]);
    if (sec[8]) lim = -lim;
    return sec[9] ? int'(r > lim) : int'(r < lim);
  endfunction

  task automatic wr16(input int idx, input logic [15:0] d);
    @(negedge clk);
    byteMode = 1'b0; hostAddr = {4'(idx), 1'b0}; hostWrData = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic wrByte(input int idx, input bit hi, input logic [7:0] b);
    @(negedge clk);
    byteMode = 1'b1; hostAddr = {4'(idx), hi}; hostWrData = {8'h00, b}; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; byteMode = 1'b0;
  endtask

  task automatic rd16(input int idx, output int v);
    byteMode = 1'b0; hostAddr = {4'(idx), 1'b0};
    #1 v = int'(hostRdData);
  endtask

  task automatic rdByte(input int idx, input bit hi, output int v);
    byteMode = 1'b1; hostAddr = {4'(idx), hi};
    #1 v = int'(hostRdData);
    byteMode = 1'b0;
  endtask

  task automatic setCfg(input bit st, input bit rs, input int sec);
    wr16(8, {6'b0, 2'(sec), 6'b0, rs, st});
  endtask

  task automatic serviceConv(input int idx, input int hold);
    int waitCnt;
    int r;
    logic [15:0] s0;
    waitCnt = 0;
    do begin
      @(negedge clk);
      waitCnt++;
    end while (!convReq && waitCnt < 8);
    checkEq("R6", "cycles to request", waitCnt, 1);
    s0 = model[idx][0];
    checkEq("R6", "instruction order", int'(convIndex), idx);
    checkEq("R5", "channel field", int'(convChannel), int'(s0[9:0]));
    checkEq("R5", "resolution field", int'(convHiRes), int'(s0[10]));
    checkEq("R5", "acquisition field", int'(convAcqTime), int'(s0[15:12]));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      checkEq("R6", "request held", int'(convReq), 1);
    end
    r = resSeed * 211 - 2000;
    resSeed++;
    convResult = 13'(r);
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    checkEq("R7", "result valid", int'(resValid), 1);
    checkEq("R7", "result data", int'(resData), r);
    checkEq("R7", "result index", int'(resIndex), idx);
    checkEq("R8", "limit 1 trip", int'(resTrip[0]), expTrip(r, model[idx][1]));
    checkEq("R8", "limit 2 trip", int'(resTrip[1]), expTrip(r, model[idx][2]));
    checkEq("R6", "request gap", int'(convReq), 0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1", "request after reset", int'(convReq), 0);
    checkEq("R1", "result after reset", int'(resValid), 0);
    rd16(8, v); checkEq("R1", "config after reset", v, 0);

    // R4 scrambled fill, R2 section pointer
    for (int s = 2; s >= 0; s--) begin
      setCfg(0, 0, s);
      for (int k = 0; k < 8; k++) begin
        int i;
        i = (k * 5 + 3) % 8;
        model[i][s] = pat(i, s);
        wr16(i, model[i][s]);
      end
    end
    for (int s = 0; s < 3; s++) begin
      setCfg(0, 0, s);
      for (int i = 0; i < 8; i++) begin
        rd16(i, v); checkEq("R4", "read back", v, int'(model[i][s]));
      end
    end

    // R2 pointer value 3
    setCfg(0, 0, 3);
    wr16(2, 16'hBEEF);
    rd16(2, v); checkEq("R2", "pointer 3 read", v, 0);
    for (int s = 0; s < 3; s++) begin
      setCfg(0, 0, s);
      rd16(2, v); checkEq("R2", "pointer 3 write dropped", v, int'(model[2][s]));
    end

    // R3 byte bus
    setCfg(0, 0, 1);
    wrByte(5, 1'b0, 8'h3C);
    wrByte(5, 1'b1, 8'hA5);
    model[5][1] = 16'hA53C;
    rdByte(5, 1'b0, v); checkEq("R3", "low byte", v, 16'h003C);
    rdByte(5, 1'b1, v); checkEq("R3", "high byte", v, 16'h00A5);
    rd16(5, v); checkEq("R3", "word after byte writes", v, 16'hA53C);
    rdByte(8, 1'b1, v); checkEq("R3", "config high byte", v, 16'h0001);
    wrByte(8, 1'b1, 8'h02);
    rd16(8, v); checkEq("R3", "config byte write", v, 16'h0200);
    rd16(5, v); checkEq("R2", "pointer selects section 2", v, int'(model[5][2]));

    // R6 run with wrap after 7
    setCfg(1, 0, 0);
    for (int k = 0; k < 10; k++) serviceConv(k % 8, k % 3);

    // R9 stop while pending
    setCfg(0, 0, 0);
    serviceConv(2, 1);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      checkEq("R9", "no request after stop", int'(convReq), 0);
    end

    // R11 write while running
    setCfg(1, 0, 0);
    wr16(4, 16'h1234);
    rd16(8, v); checkEq("R11", "error flag set", v, 16'h0401);
    rd16(4, v); checkEq("R11", "read blocked while running", v, 0);
    setCfg(0, 0, 0);
    serviceConv(3, 0);
    rd16(4, v); checkEq("R11", "write dropped", v, int'(model[4][0]));
    rd16(8, v); checkEq("R11", "error flag sticky", v, 16'h0400);

    // R10 soft reset mid instruction
    setCfg(1, 0, 0);
    @(negedge clk);
    checkEq("R9", "resume at next instruction", int'(convIndex), 4);
    wr16(8, 16'h0003);
    checkEq("R10", "request dropped", int'(convReq), 0);
    rd16(8, v); checkEq("R10", "reset bit visible", v, 16'h0002);
    @(negedge clk);
    rd16(8, v); checkEq("R10", "reset bit self clear", v, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      checkEq("R10", "start cleared", int'(convReq), 0);
    end

    // R6 loop-end mark on instruction 3, R10 pointer rewound
    model[3][0] = model[3][0] | 16'h0800;
    wr16(3, model[3][0]);
    setCfg(1, 0, 0);
    serviceConv(0, 2);
    serviceConv(1, 0);
    serviceConv(2, 1);
    serviceConv(3, 0);
    serviceConv(0, 1);
    wr16(8, 16'h0002);
    finishRun();
  end
endmodule